// File: doc/BRIEF.md
# Receive start-of-frame lane aligner

This block sits on a 64-bit receive path that carries eight byte lanes. Each lane has its own control flag. A frame's start character may arrive in lane 0 or in lane 4. Downstream logic is simpler if every frame begins in lane 0, so the block moves the stream into that position. When a start turns up in the upper half, the block shifts by four bytes. It keeps shifting every later word until another start is seen.

The shift is built from the current word's lower half and the upper half of the word before it. So the block remembers two things across words: whether it is shifting, and the previous upper half. When a shift begins straight after unshifted traffic, no earlier upper half belongs to the stream, and the freed lower half is filled with idle characters. Data and control flags leave through one register stage.

Top module: `lane_aligner`

## Requirements
- R1: A synchronous active-high reset clears the output data, the output control flags, the stored upper half and the shift mode. After reset, a word with no start passes through unchanged.
- R2: A word whose lane 0 (data bits [7:0]) holds 0xFB with control bit 0 set is output unchanged, and the shift mode is cleared.
- R3: With the shift mode clear, a word that is not covered by R2 and whose lane 4 (data bits [39:32]) holds 0xFB with control bit 4 set gives an output whose lanes 4–7 are the input's lanes 0–3. Its lanes 0–3 are 0x07 with control bits 3:0 all set. The shift mode is then set.
- R4: With the shift mode set, a lane-4 start as in R3 gives an output whose lanes 0–3 are the previous input word's lanes 4–7 and their control bits. Its lanes 4–7 are the current lanes 0–3.
- R5: With the shift mode set, a word with no start gives an output of the current lanes 0–3 above the previous word's lanes 4–7. Control bits move the same way.
- R6: With the shift mode clear, a word with no start is output unchanged.
- R7: A byte of 0xFB whose control bit is clear is plain data and is never taken as a start, in lane 0 or in lane 4.
- R8: When lane 0 and lane 4 both hold a start, the lane 0 start decides, and R2 applies.
- R9: The output data and control flags change together, one clock edge after the input word is presented, and never before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 64 | Received word; lane n is bits [8n+7:8n] |
| in_ctl | input | 8 | Control flag per lane |
| out_data | output | 64 | Aligned word, registered |
| out_ctl | output | 8 | Aligned control flags, registered |

## Verification
Six word kinds are swept over every ordered sequence of three: no start, a lane 0 start, a lane 4 start, starts in both lanes, and a bare 0xFB data byte in lane 0 or in lane 4. The sweep starts each sequence from whatever shift mode the sequence before it left behind. This separates a lane-4 start that fills with idles from one that carries the stored upper half, and it separates shifted pass-through from plain pass-through. The bare-byte kinds show that a start is recognised only when its control flag is set. The both-lanes kind shows that lane 0 wins. A reset in the middle of a shifted stream shows that the mode really is cleared.

// File: rtl/la_pkg.sv
package la_pkg;
  localparam logic [7:0] SOF_CHAR  = 8'hFB;
  localparam logic [7:0] IDLE_CHAR = 8'h07;
endpackage

// File: rtl/la_start_detect.sv
module la_start_detect #(
  parameter int LANES  = 8,
  parameter int BYTE_W = 8
) (
  input  logic [LANES*BYTE_W-1:0] data_i,
  input  logic [LANES-1:0]        ctl_i,
  output logic [LANES-1:0]        is_start_o
);
  import la_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign is_start_o[g] = ctl_i[g] &&
                           (data_i[g*BYTE_W +: BYTE_W] == BYTE_W'(SOF_CHAR));
  end
endmodule

// File: rtl/la_shift_state.sv
module la_shift_state #(
  parameter int LANES  = 8,
  parameter int BYTE_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [LANES/2*BYTE_W-1:0]       hi_data_i,
  input  logic [LANES/2-1:0]              hi_ctl_i,
  input  logic                            start_lo_i,
  input  logic                            start_hi_i,
  output logic                            shift_q,
  output logic [LANES/2*BYTE_W-1:0]       prev_data_q,
  output logic [LANES/2-1:0]              prev_ctl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q     <= 1'b0;
      prev_data_q <= '0;
      prev_ctl_q  <= '0;
    end else begin
      prev_data_q <= hi_data_i;
      prev_ctl_q  <= hi_ctl_i;
      if (start_lo_i)      shift_q <= 1'b0;
      else if (start_hi_i) shift_q <= 1'b1;
    end
  end
endmodule

// File: rtl/la_out_mux.sv
module la_out_mux #(
  parameter int LANES  = 8,
  parameter int BYTE_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [LANES*BYTE_W-1:0]         data_i,
  input  logic [LANES-1:0]                ctl_i,
  input  logic                            start_lo_i,
  input  logic                            start_hi_i,
  input  logic                            shift_q_i,
  input  logic [LANES/2*BYTE_W-1:0]       prev_data_i,
  input  logic [LANES/2-1:0]              prev_ctl_i,
  output logic [LANES*BYTE_W-1:0]         data_o,
  output logic [LANES-1:0]                ctl_o
);
  import la_pkg::*;
  localparam int HALF = LANES / 2;
  localparam int HW   = HALF * BYTE_W;

  logic [HW-1:0]   low_d;
  logic [HALF-1:0] low_c;
  logic [LANES*BYTE_W-1:0] nxt_d;
  logic [LANES-1:0]        nxt_c;

  always_comb begin
    if (shift_q_i) begin
      low_d = prev_data_i;
      low_c = prev_ctl_i;
    end else begin
      low_d = {HALF{BYTE_W'(IDLE_CHAR)}};
      low_c = '1;
    end
    if (start_lo_i) begin
      nxt_d = data_i;
      nxt_c = ctl_i;
    end else if (start_hi_i) begin
      nxt_d = {data_i[HW-1:0], low_d};
      nxt_c = {ctl_i[HALF-1:0], low_c};
    end else if (shift_q_i) begin
      nxt_d = {data_i[HW-1:0], prev_data_i};
      nxt_c = {ctl_i[HALF-1:0], prev_ctl_i};
    end else begin
      nxt_d = data_i;
      nxt_c = ctl_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      ctl_o  <= '0;
    end else begin
      data_o <= nxt_d;
      ctl_o  <= nxt_c;
    end
  end
endmodule

// File: rtl/lane_aligner.sv
module lane_aligner #(
  parameter int LANES  = 8,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES*BYTE_W-1:0] in_data,
  input  logic [LANES-1:0]        in_ctl,
  output logic [LANES*BYTE_W-1:0] out_data,
  output logic [LANES-1:0]        out_ctl
);
  localparam int HALF = LANES / 2;
  localparam int HW   = HALF * BYTE_W;
  localparam int W    = LANES * BYTE_W;

  logic [LANES-1:0] is_start;
  logic             shift_q;
  logic [HW-1:0]    prev_d;
  logic [HALF-1:0]  prev_c;

  la_start_detect #(.LANES(LANES), .BYTE_W(BYTE_W)) u_det (
    .data_i(in_data), .ctl_i(in_ctl), .is_start_o(is_start)
  );

  la_shift_state #(.LANES(LANES), .BYTE_W(BYTE_W)) u_state (
    .clk(clk), .rst(rst),
    .hi_data_i(in_data[W-1:HW]), .hi_ctl_i(in_ctl[LANES-1:HALF]),
    .start_lo_i(is_start[0]), .start_hi_i(is_start[HALF]),
    .shift_q(shift_q), .prev_data_q(prev_d), .prev_ctl_q(prev_c)
  );

  la_out_mux #(.LANES(LANES), .BYTE_W(BYTE_W)) u_mux (
    .clk(clk), .rst(rst), .data_i(in_data), .ctl_i(in_ctl),
    .start_lo_i(is_start[0]), .start_hi_i(is_start[HALF]),
    .shift_q_i(shift_q), .prev_data_i(prev_d), .prev_ctl_i(prev_c),
    .data_o(out_data), .ctl_o(out_ctl)
  );
endmodule

// File: rtl/lane_aligner_chk.sv
module lane_aligner_chk #(
  parameter int LANES  = 8,
  parameter int BYTE_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [LANES*BYTE_W-1:0] in_data,
  input logic [LANES-1:0]        in_ctl,
  input logic [LANES*BYTE_W-1:0] out_data,
  input logic [LANES-1:0]        out_ctl
);
  import la_pkg::*;
  localparam int HALF = LANES / 2;
  localparam int HW   = HALF * BYTE_W;
  localparam int W    = LANES * BYTE_W;

  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  logic s0, s4;
  assign s0 = in_ctl[0] && (in_data[BYTE_W-1:0] == BYTE_W'(SOF_CHAR));
  assign s4 = in_ctl[HALF] && (in_data[HW +: BYTE_W] == BYTE_W'(SOF_CHAR));

  a_r1_reset_clears: assert property (@(posedge clk)
    (primed && $past(rst)) |-> (out_data == '0 && out_ctl == '0));

  a_r2_lane0_passthrough: assert property (@(posedge clk) disable iff (rst)
    s0 |=> (out_data == $past(in_data) && out_ctl == $past(in_ctl)));

  a_r3_upper_from_low: assert property (@(posedge clk) disable iff (rst)
    (!s0 && s4) |=> (out_data[W-1:HW] == $past(in_data[HW-1:0]) &&
                     out_ctl[LANES-1:HALF] == $past(in_ctl[HALF-1:0])));

  a_r4_lower_from_prev: assert property (@(posedge clk) disable iff (rst)
    (!s0 && s4) ##1 (!s0 && s4) |=>
      (out_data[HW-1:0] == $past(in_data[W-1:HW], 2) &&
       out_ctl[HALF-1:0] == $past(in_ctl[LANES-1:HALF], 2)));

  a_r6_plain_after_lane0: assert property (@(posedge clk) disable iff (rst)
    s0 ##1 (!s0 && !s4) |=> (out_data == $past(in_data) && out_ctl == $past(in_ctl)));
endmodule

bind lane_aligner lane_aligner_chk #(.LANES(LANES), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .in_data(in_data), .in_ctl(in_ctl),
  .out_data(out_data), .out_ctl(out_ctl)
);

// File: tb/test_lane_aligner.sv
module test_lane_aligner;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] in_data = '0;
  logic [7:0]  in_ctl = '0;
  logic [63:0] out_data;
  logic [7:0]  out_ctl;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic        m_shift = 1'b0;
  logic [31:0] m_prev_d = '0;
  logic [3:0]  m_prev_c = '0;
  logic [63:0] last_d = '0;
  logic [7:0]  last_c = '0;

  always #10 clk = ~clk;

  lane_aligner i_lane_aligner (
    .clk(clk), .rst(rst), .in_data(in_data), .in_ctl(in_ctl),
    .out_data(out_data), .out_ctl(out_ctl)
  );

  task automatic check(input string tag, input logic [63:0] ed, input logic [7:0] ec);
    checks++;
    if (out_data !== ed || out_ctl !== ec) begin
      fails++;
      $display("FAIL %s: got %h/%h expected %h/%h", tag, out_data, out_ctl, ed, ec);
    end
  endtask

  // Called at a negedge: presents a word, checks R9 before the edge and the result after it.
  task automatic apply(input logic [63:0] d, input logic [7:0] c, input string tag);
    logic s0, s4;
    logic [63:0] ed;
    logic [7:0]  ec;
    s0 = c[0] && d[7:0] == 8'hFB;
    s4 = c[4] && d[39:32] == 8'hFB;
    if (s0) begin
      ed = d; ec = c;
    end else if (s4) begin
      ed = {d[31:0], m_shift ? m_prev_d : 32'h07070707};
      ec = {c[3:0], m_shift ? m_prev_c : 4'hF};
    end else if (m_shift) begin
      ed = {d[31:0], m_prev_d}; ec = {c[3:0], m_prev_c};
    end else begin
      ed = d; ec = c;
    end
    in_data = d; in_ctl = c;
    #1 check("R9 early change", last_d, last_c);
    @(negedge clk);
    check(tag, ed, ec);
    if (s0) m_shift = 1'b0; else if (s4) m_shift = 1'b1;
    m_prev_d = d[63:32]; m_prev_c = c[7:4];
    last_d = ed; last_c = ec;
  endtask

  function automatic logic [63:0] gen_d(input int n, input int kind);
    logic [63:0] d;
    d = {32'(n) * 32'h9E3779B1, 32'(n + 7) * 32'h85EBCA6B};
    if (d[7:0] == 8'hFB) d[7:0] = 8'h5A;
    if (d[39:32] == 8'hFB) d[39:32] = 8'h5A;
    if (kind == 1 || kind == 3 || kind == 4) d[7:0] = 8'hFB;
    if (kind == 2 || kind == 3 || kind == 5) d[39:32] = 8'hFB;
    return d;
  endfunction

  function automatic logic [7:0] gen_c(input int n, input int kind);
    logic [7:0] c;
    c = 8'(n * 37 + 11);
    if (kind == 1 || kind == 3) c[0] = 1'b1;
    if (kind == 2 || kind == 3) c[4] = 1'b1;
    if (kind == 4) c[0] = 1'b0;
    if (kind == 5) c[4] = 1'b0;
    return c;
  endfunction

  function automatic string tag_of(input int kind, input logic sh);
    case (kind)
      1: return "R2 lane0 start";
      2: return sh ? "R4 lane4 start shifted" : "R3 lane4 start idle fill";
      3: return "R8 both starts";
      4, 5: return "R7 bare data byte";
      default: return sh ? "R5 shifted no start" : "R6 plain no start";
    endcase
  endfunction

  initial begin
    int n;
    n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", '0, '0);
    rst = 1'b0;
    apply(64'h0123_4567_89AB_CDEF, 8'h22, "R1 after reset passthrough");
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 6; b++)
        for (int k = 0; k < 6; k++) begin
          apply(gen_d(n, a), gen_c(n, a), tag_of(a, m_shift)); n++;
          apply(gen_d(n, b), gen_c(n, b), tag_of(b, m_shift)); n++;
          apply(gen_d(n, k), gen_c(n, k), tag_of(k, m_shift)); n++;
        end
    apply(gen_d(n, 2), gen_c(n, 2), "R3 before reset"); n++;
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", '0, '0);
    rst = 1'b0;
    m_shift = 1'b0; m_prev_d = '0; m_prev_c = '0; last_d = '0; last_c = '0;
    apply(gen_d(n, 0), gen_c(n, 0), "R1 mode cleared by reset"); n++;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule